// File: doc/BRIEF.md
# High-speed USB transmit serializer

The block turns a packet delivered as 16-bit parallel words into a serial high-speed USB bit stream, one line bit per fast-clock cycle. The sender supplies everything as data: the sync field (word 0000H then word 8000H, which yields 31 zeros and then a one), the packet bytes, and a trailing end-of-packet byte FEH. Inside the block, each word is taken apart low byte first, each byte least-significant bit first. A zero is inserted after every run of six ones. The result is NRZI encoded.

Words move over a valid/ready handshake. A per-word mark flags the final word of a packet and says how its two bytes are handled. If the upper byte of a marked word is FEH, then the lower byte is the last data byte and the upper byte is the end-of-packet byte, so the packet ends on an 8-bit boundary. Otherwise the lower byte is the end-of-packet byte and the upper byte is dropped, so the packet ends on a 16-bit boundary. The end-of-packet byte goes out without stuffing, which gives the intended stuff violation. After that the line drive enable drops and the line rests at its idle level.

Ready rises again during the cycle in which a word's last bit goes out. A sender that holds valid high therefore gets a gapless stream, however many stuff bits were inserted.

Top module: `hs_tx_serializer`

## Requirements
- R1: Ready is high whenever the block holds no word, including right after reset. A word is accepted on the rising clock edge at which valid and ready are both high. After reset, line_en_o is 0 and line_o is 1.
- R2: In the cycle right after an accepted word, ready is 0. It goes high again only in the cycle in which the last bit of a non-final word is sent. With valid held high, consecutive words therefore produce a stream with no gap.
- R3: Bits of a word are sent lower byte (bits 7:0) first and then upper byte (bits 15:8), each byte least-significant bit first.
- R4: In data bytes, after six consecutive one bits a zero is inserted. The run count carries across byte and word boundaries, and no run of more than six ones appears in data.
- R5: In a word accepted with tx_mark_i = 1, if bits 15:8 equal FEH then bits 7:0 are data and bits 15:8 are the end-of-packet byte. Otherwise bits 7:0 are the end-of-packet byte and bits 15:8 are not sent.
- R6: The end-of-packet byte is sent with no stuff bits. A stuff zero owed by the last six data ones is still sent before it.
- R7: NRZI: a zero bit toggles line_o and a one bit leaves it unchanged. Each packet starts from level 1.
- R8: line_en_o is high for exactly the cycles that carry the packet's bits. It falls in the cycle after the last end-of-packet bit, and line_o is 1 whenever line_en_o is 0.
- R9: When a packet starts from idle, its first bit appears on line_o two rising edges after the edge that accepted its first word.
- R10: An unmarked word whose bytes equal FEH is ordinary data and is stuffed like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | 16 | Parallel word to send |
| tx_valid_i | input | 1 | tx_data_i holds a word |
| tx_mark_i | input | 1 | Word is the final one of the packet (see R5) |
| tx_ready_o | output | 1 | Word is taken at the next rising edge if valid |
| line_o | output | 1 | NRZI line level |
| line_en_o | output | 1 | Line driven with packet bits |

## Verification
The bench first goes after stuffing at the edges of bytes and words. It sends runs of FFFFH that cross boundaries, and a word whose last data bits are six ones right before the end-of-packet byte. A design that resets its run count per byte, or that drops the owed stuff bit, shifts the rest of the line pattern. Both end-of-packet placements are sent, as is an unmarked FEH data word. A design that stuffs the end byte, decodes the mark wrongly or sends the discarded upper byte gets a different line pattern or packet length. The bench also checks that ready falls after every accept and that the first bit arrives with the stated latency. An early ready, or a bubble between words, shows up as a length mismatch on the drive enable.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;

    localparam logic [7:0] EOP_BYTE_DEF = 8'hFE;
    localparam logic       IDLE_LEVEL   = 1'b1;

    typedef struct packed {
        logic level;
        logic en;
    } line_t;

    // NRZI: a zero flips the level, a one keeps it
    function automatic logic nrzi_step(input logic prev, input logic b);
        return b ? prev : ~prev;
    endfunction

endpackage

// File: rtl/hs_tx_shifter.sv
module hs_tx_shifter #(
    parameter int         WORD_W   = 16,
    parameter logic [7:0] EOP_BYTE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_i,
    input  logic              valid_i,
    input  logic              mark_i,
    output logic              ready_o,
    input  logic              advance_i,
    output logic              has_bit_o,
    output logic              bit_o,
    output logic              eop_bit_o
);
    localparam int BYTE_W = WORD_W / 2;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int POS_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [POS_W-1:0]  pos;
        logic [POS_W-1:0]  eop_from;
        logic [POS_W-1:0]  last_pos;
        logic              fin;
        logic              full;
    } sh_t;

    sh_t  s_d, s_q;
    logic at_last;
    logic hi_is_eop;

    always_comb begin
        at_last   = (s_q.pos == s_q.last_pos);
        hi_is_eop = (data_i[WORD_W-1:BYTE_W] == BYTE_W'(EOP_BYTE));
        ready_o   = !s_q.full || (advance_i && at_last && !s_q.fin);
        s_d       = s_q;
        if (advance_i) begin
            if (at_last) s_d.full = 1'b0;
            else         s_d.pos  = s_q.pos + POS_W'(1);
        end
        if (ready_o && valid_i) begin
            s_d.word = data_i;
            s_d.full = 1'b1;
            s_d.pos  = '0;
            s_d.fin  = mark_i;
            if (!mark_i) begin
                s_d.eop_from = POS_W'(WORD_W);
                s_d.last_pos = POS_W'(WORD_W - 1);
            end else if (hi_is_eop) begin
                s_d.eop_from = POS_W'(BYTE_W);
                s_d.last_pos = POS_W'(WORD_W - 1);
            end else begin
                s_d.eop_from = '0;
                s_d.last_pos = POS_W'(BYTE_W - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign has_bit_o = s_q.full;
    assign bit_o     = s_q.word[s_q.pos[IDX_W-1:0]];
    assign eop_bit_o = (s_q.pos >= s_q.eop_from);

endmodule

// File: rtl/hs_tx_stuffer.sv
module hs_tx_stuffer #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic has_bit_i,
    input  logic bit_i,
    input  logic eop_bit_i,
    output logic advance_o,
    output logic emit_o,
    output logic emit_bit_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
    } st_t;

    st_t  s_d, s_q;
    logic stuff;

    always_comb begin
        stuff      = has_bit_i && (s_q.ones == CNT_W'(RUN_LEN));
        emit_o     = has_bit_i;
        emit_bit_o = stuff ? 1'b0 : bit_i;
        advance_o  = has_bit_i && !stuff;
        s_d        = s_q;
        if (!has_bit_i || stuff || eop_bit_i || !bit_i) s_d.ones = '0;
        else                                            s_d.ones = s_q.ones + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/hs_tx_nrzi.sv
module hs_tx_nrzi
    import hs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic emit_i,
    input  logic bit_i,
    output logic line_o,
    output logic en_o
);
    line_t s_d, s_q;

    always_comb begin
        s_d.en    = emit_i;
        s_d.level = emit_i ? nrzi_step(s_q.level, bit_i) : IDLE_LEVEL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{level: IDLE_LEVEL, en: 1'b0};
        else        s_q <= s_d;
    end

    assign line_o = s_q.level;
    assign en_o   = s_q.en;

endmodule

// File: rtl/hs_tx_serializer.sv
module hs_tx_serializer
    import hs_tx_pkg::*;
#(
    parameter int         WORD_W   = 16,
    parameter int         RUN_LEN  = 6,
    parameter logic [7:0] EOP_BYTE = EOP_BYTE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic              tx_mark_i,
    output logic              tx_ready_o,
    output logic              line_o,
    output logic              line_en_o
);
    logic advance, has_bit, cur_bit, eop_bit, emit, emit_bit;

    hs_tx_shifter #(.WORD_W(WORD_W), .EOP_BYTE(EOP_BYTE)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (tx_data_i),
        .valid_i   (tx_valid_i),
        .mark_i    (tx_mark_i),
        .ready_o   (tx_ready_o),
        .advance_i (advance),
        .has_bit_o (has_bit),
        .bit_o     (cur_bit),
        .eop_bit_o (eop_bit)
    );

    hs_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk        (clk),
        .rst_n      (rst_n),
        .has_bit_i  (has_bit),
        .bit_i      (cur_bit),
        .eop_bit_i  (eop_bit),
        .advance_o  (advance),
        .emit_o     (emit),
        .emit_bit_o (emit_bit)
    );

    hs_tx_nrzi u_nrzi (
        .clk    (clk),
        .rst_n  (rst_n),
        .emit_i (emit),
        .bit_i  (emit_bit),
        .line_o (line_o),
        .en_o   (line_en_o)
    );

endmodule

// File: rtl/hs_tx_checks.sv
module hs_tx_checks (
    input logic clk,
    input logic rst_n,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic line_o,
    input logic line_en_o
);
    logic       prev_line_q;
    logic [3:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_line_q <= 1'b1;
            run_q       <= '0;
        end else begin
            prev_line_q <= line_o;
            if (!line_en_o)                               run_q <= '0;
            else if (line_o == prev_line_q && run_q != 4'hF) run_q <= run_q + 4'd1;
            else if (line_o != prev_line_q)               run_q <= '0;
        end
    end

    // R2: after an accept, ready stays low for at least one cycle
    assert_accept_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

    // R9: a packet started from idle reaches the line two edges later
    assert_start_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o && !line_en_o) |-> ##2 line_en_o);

    // R8: idle line rests at level 1
    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en_o |-> line_o);

    // R4: longest run of decoded ones is the end byte's seven
    assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 4'd7);

    // R1: ready is high while the line is idle with no word accepted
    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_en_o && !$past(line_en_o) && !$past(tx_valid_i)) |-> tx_ready_o);

endmodule

bind hs_tx_serializer hs_tx_checks u_chk (.*);

// File: tb/hs_tx_serializer_test.sv
module hs_tx_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_data_i = '0;
    logic        tx_valid_i = 1'b0;
    logic        tx_mark_i = 1'b0;
    logic        tx_ready_o, line_o, line_en_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] pkt[$];
    logic        exp_q[$];
    int          len_q[$];
    string       cur_tag = "R7";

    always #4 clk = ~clk;

    hs_tx_serializer uut (
        .clk(clk), .rst_n(rst_n), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
        .tx_mark_i(tx_mark_i), .tx_ready_o(tx_ready_o), .line_o(line_o),
        .line_en_o(line_en_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected line levels from the requirements
    task automatic build_expect();
        int   ones = 0;
        int   n = 0;
        logic lvl = 1'b1;
        for (int i = 0; i < pkt.size(); i++) begin
            logic [15:0] w = pkt[i];
            bit fin = (i == pkt.size() - 1);
            int ndata = fin ? ((w[15:8] == 8'hFE) ? 8 : 0) : 16;
            int ntot  = (fin && w[15:8] != 8'hFE) ? 8 : 16;
            for (int b = 0; b < ntot; b++) begin
                if (!w[b]) lvl = ~lvl;
                exp_q.push_back(lvl);
                n++;
                if (b < ndata) begin
                    ones = w[b] ? ones + 1 : 0;
                    if (ones == 6) begin
                        lvl = ~lvl;
                        exp_q.push_back(lvl);
                        n++;
                        ones = 0;
                    end
                end
            end
        end
        len_q.push_back(n);
    endtask

    task automatic run_packet(input string tag);
        bit fresh;
        cur_tag = tag;
        build_expect();
        fresh = !line_en_o;
        for (int i = 0; i < pkt.size(); i++) begin
            tx_data_i  = pkt[i];
            tx_mark_i  = (i == pkt.size() - 1);
            tx_valid_i = 1'b1;
            while (!tx_ready_o) @(negedge clk);
            @(negedge clk);
            check("R2 ready low after accept", tx_ready_o, 1'b0);
            if (i == 0 && fresh) check("R9 line idle one cycle after accept", line_en_o, 1'b0);
        end
        tx_valid_i = 1'b0;
        tx_mark_i  = 1'b0;
        while (exp_q.size() != 0 || line_en_o) @(negedge clk);
        @(negedge clk);
        check("R1 ready when idle", tx_ready_o, 1'b1);
        pkt.delete();
    endtask

    // monitor: compares every driven line bit and each packet's length
    int   run_len = 0;
    logic prev_en = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_en_o) begin
                if (exp_q.size() == 0) begin
                    check_int({cur_tag, " R8 extra line bit"}, 1, 0);
                end else begin
                    check({cur_tag, " R7 line level"}, line_o, exp_q.pop_front());
                end
                run_len++;
            end else if (prev_en) begin
                if (len_q.size() != 0) check_int({cur_tag, " R8 packet length"}, run_len, len_q.pop_front());
                check("R8 idle level", line_o, 1'b1);
                run_len = 0;
            end
            prev_en = line_en_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ready", tx_ready_o, 1'b1);
        check("R1 reset line_en", line_en_o, 1'b0);
        check("R1 reset line", line_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        pkt = '{16'h0000, 16'h8000, 16'h1234, 16'hA5C3, 16'hFE5A};
        run_packet("R3 R5");

        pkt = '{16'h0000, 16'h8000, 16'h0F81, 16'h00FE};
        run_packet("R5");

        pkt = '{16'h0000, 16'h8000, 16'hFFFF, 16'hFFFF, 16'h7FFE, 16'hFE0F};
        run_packet("R4");

        pkt = '{16'h0000, 16'h8000, 16'h1111, 16'hFEFC};
        run_packet("R6");

        pkt = '{16'h0000, 16'h8000, 16'hFC00, 16'h00FE};
        run_packet("R6 R5");

        pkt = '{16'h0000, 16'h8000, 16'hFEFE, 16'hFE01};
        run_packet("R10");

        pkt = '{16'hFFFF, 16'h3FFF, 16'h80FE};
        run_packet("R2 R4");

        pkt = '{16'h5555, 16'hFE00};
        run_packet("R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule